// File: doc/BRIEF.md
# SMRAM Access Control Register with Sticky Lock

This block holds the byte-wide control register that governs how system-management memory is exposed. Four control fields live in it: a global enable, a close field, an open field that makes the protected memory visible outside the management mode, and a lock field. Software reaches the register through a simple write strobe with a byte of data. The current value is always visible on a read bus. The four fields also leave the block as registered status lines for the memory decoder.

The lock field is the security anchor. Once software sets it, the open field is forced to zero in that same update. From then on no write can change any field, and only a synchronous reset releases the register. Firmware normally sets enable and close with lock clear, then sets lock in a final write.

Top module: `smram_ctl`

## Requirements
- R1: In the cycle after a synchronous reset, the read value is 8'h02 and all four status outputs are low.
- R2: While lock is clear, a write sets or clears the open field from data bit 6, and the read value shows the written state after the next clock edge.
- R3: While lock is clear, a write loads the close field from data bit 5 and the global enable field from data bit 3.
- R4: A write with data bit 4 set while lock is clear sets lock and leaves open at 0 in the same update, even when data bit 6 is also 1.
- R5: While lock is set, every write leaves all four fields unchanged, so open keeps reading 0.
- R6: A reset clears lock, and after it the open field is writable again.
- R7: Read bit 7 is always 0 and read bits 2:0 are always 3'b010, whatever data is written.
- R8: In a cycle without a write strobe the register keeps its value.
- R9: The open, close, lock and enable outputs always equal read bits 6, 5, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Byte write strobe, one cycle per write |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rdata | output | 8 | Current register value |
| smram_open | output | 1 | Open field status |
| smram_close | output | 1 | Close field status |
| smram_lock | output | 1 | Lock field status |
| smram_enable | output | 1 | Global enable status |

## Verification
The open field is toggled both ways with lock clear, to show that it is writable before locking. A lock write is issued with open also set, which separates a design that clears open in the same update from one that keeps it. After locking, a sweep of all 256 data values tries to reopen, clear enable, clear close and clear lock; any field that moves shows a freeze that is not complete. The run then resets and toggles open again, and writes the reserved bits as all ones and all zeros, to show recovery and the fixed read-back constant.

// File: rtl/smram_ctl_pkg.sv
package smram_ctl_pkg;
  localparam int unsigned CFG_W   = 8;
  localparam int unsigned POS_OPN = 6;
  localparam int unsigned POS_CLS = 5;
  localparam int unsigned POS_LCK = 4;
  localparam int unsigned POS_ENA = 3;
  localparam int unsigned FIX_W   = 3;
  localparam logic [FIX_W-1:0] FIX_VAL = 3'b010;

  typedef struct packed {
    logic opn;
    logic cls;
    logic lck;
    logic ena;
  } smram_fields_t;

  localparam smram_fields_t FIELDS_RST = '{opn: 1'b0, cls: 1'b0, lck: 1'b0, ena: 1'b0};
endpackage

// File: rtl/smram_next.sv
module smram_next
  import smram_ctl_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  smram_fields_t cur,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  output smram_fields_t nxt
);
  always_comb begin
    nxt = cur;
    if (wr && !cur.lck) begin
      nxt.lck = wdata[POS_LCK];
      nxt.opn = wdata[POS_OPN] & ~wdata[POS_LCK];
      nxt.cls = wdata[POS_CLS];
      nxt.ena = wdata[POS_ENA];
    end
  end
endmodule

// File: rtl/smram_state.sv
module smram_state
  import smram_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  smram_fields_t nxt,
  output smram_fields_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= FIELDS_RST;
    else     q <= nxt;
  end
endmodule

// File: rtl/smram_ctl.sv
module smram_ctl
  import smram_ctl_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_wr,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  output logic         smram_open,
  output logic         smram_close,
  output logic         smram_lock,
  output logic         smram_enable
);
  smram_fields_t cur_q;
  smram_fields_t nxt_d;

  smram_next #(.W(W)) u_next (
    .cur   (cur_q),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .nxt   (nxt_d)
  );

  smram_state u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_d),
    .q   (cur_q)
  );

  always_comb begin
    cfg_rdata                = '0;
    cfg_rdata[FIX_W-1:0]     = FIX_VAL;
    cfg_rdata[POS_OPN]       = cur_q.opn;
    cfg_rdata[POS_CLS]       = cur_q.cls;
    cfg_rdata[POS_LCK]       = cur_q.lck;
    cfg_rdata[POS_ENA]       = cur_q.ena;
  end

  assign smram_open   = cur_q.opn;
  assign smram_close  = cur_q.cls;
  assign smram_lock   = cur_q.lck;
  assign smram_enable = cur_q.ena;
endmodule

// File: rtl/smram_ctl_chk.sv
module smram_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr,
  input logic [7:0] cfg_rdata,
  input logic       smram_open,
  input logic       smram_close,
  input logic       smram_lock,
  input logic       smram_enable
);
  // R1: reset lands on the fixed value
  p_reset_val_r1: assert property (@(posedge clk) rst |=> (cfg_rdata == 8'h02));
  // R4: open never coexists with lock
  p_open_clr_r4: assert property (@(posedge clk) disable iff (rst) smram_lock |-> !smram_open);
  // R5: lock is sticky and freezes the whole value
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (rst) smram_lock |=> smram_lock);
  p_frozen_r5: assert property (@(posedge clk) disable iff (rst) smram_lock |=> $stable(cfg_rdata));
  // R7: fixed bits
  p_fixed_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[2:0] == 3'b010) && !cfg_rdata[7]);
  // R8: no strobe, no change
  p_idle_r8: assert property (@(posedge clk) disable iff (rst) !cfg_wr |=> $stable(cfg_rdata));
  // R9: status lines mirror the read bits
  p_status_r9: assert property (@(posedge clk) disable iff (rst)
    {smram_open, smram_close, smram_lock, smram_enable} == cfg_rdata[6:3]);
endmodule

bind smram_ctl smram_ctl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_wr       (cfg_wr),
  .cfg_rdata    (cfg_rdata),
  .smram_open   (smram_open),
  .smram_close  (smram_close),
  .smram_lock   (smram_lock),
  .smram_enable (smram_enable)
);

// File: tb/smram_ctl_bench.sv
module smram_ctl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       smram_open, smram_close, smram_lock, smram_enable;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model
  bit m_open = 0, m_close = 0, m_lock = 0, m_ena = 0;

  always #2 clk = ~clk;

  smram_ctl u_smram_ctl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .smram_open(smram_open), .smram_close(smram_close),
    .smram_lock(smram_lock), .smram_enable(smram_enable)
  );

  function automatic logic [7:0] exp_byte();
    return {1'b0, m_open, m_close, m_lock, m_ena, 3'b010};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_open <= 0; m_close <= 0; m_lock <= 0; m_ena <= 0;
    end else if (cfg_wr && !m_lock) begin
      m_lock  <= cfg_wdata[4];
      m_open  <= cfg_wdata[6] && !cfg_wdata[4];
      m_close <= cfg_wdata[5];
      m_ena   <= cfg_wdata[3];
    end
  end

  // per-cycle comparison against the model (R9 covers the status lines)
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (cfg_rdata !== exp_byte()) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", cur_req, cfg_rdata, exp_byte());
      end
      checks++;
      if ({smram_open, smram_close, smram_lock, smram_enable} !== {m_open, m_close, m_lock, m_ena}) begin
        errors++;
        $display("FAIL R9: status actual %b expected %b",
          {smram_open, smram_close, smram_lock, smram_enable}, {m_open, m_close, m_lock, m_ena});
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0; cfg_wdata = 8'h00;
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    @(negedge clk);
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata actual %h expected %h", req, cfg_rdata, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1"; chk("R1", 8'h02);
    cur_req = "R2";
    wr(8'h00); chk("R2", 8'h02);
    wr(8'h40); chk("R2", 8'h42);
    wr(8'h00); chk("R2", 8'h02);
    cur_req = "R3";
    wr(8'h28); chk("R3", 8'h2A);
    wr(8'h48); chk("R3", 8'h4A);
    cur_req = "R7";
    wr(8'h87); chk("R7", 8'h02);
    cur_req = "R8";
    wr(8'h68);
    repeat (5) @(negedge clk);
    chk("R8", 8'h6A);
    cur_req = "R4";
    wr(8'h78); chk("R4", 8'h3A);
    cur_req = "R5";
    for (int i = 0; i < 256; i++) wr(i[7:0]);
    chk("R5", 8'h3A);
    cur_req = "R6";
    do_reset(); chk("R6", 8'h02);
    wr(8'h40); chk("R6", 8'h42);
    wr(8'h00); chk("R6", 8'h02);
    cur_req = "R4";
    wr(8'h50); chk("R4", 8'h12);
    cur_req = "R5";
    wr(8'h40); chk("R5", 8'h12);
    cur_req = "R1";
    do_reset(); chk("R1", 8'h02);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule